// File: doc/BRIEF.md
# Configurable UART serial transmitter

This block sends one character at a time on a single serial line. A host presents a byte with a valid/ready handshake. The block then emits a start bit, the data bits least significant first, an optional parity bit and the stop period. A line-control byte sets the framing: the character length, whether parity is present, its sense, constant ("stick") parity, the stop-bit count and a break override.

Every bit time is counted in baud ticks. A baud tick is a one-cycle pulse supplied from outside at 16 times the bit rate. The framing fields are captured when a character is accepted and are held until that character ends. The break bit is the exception: it acts on the line at once, whenever it is set.

Line-control layout used throughout:
- bits [1:0]: length code.
- bit 2: stop select.
- bit 3: parity enable.
- bit 4: even select.
- bit 5: stick parity.
- bit 6: break.
- bit 7: unused.

Top module: `uart_frame_tx`

## Requirements
- R1: line_ctl[1:0] sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that length are not sent.
- R2: The idle line is 1. A character starts with a 0 start bit. The data bits follow, least significant bit first. Each bit, the start bit included, lasts 16 baud ticks.
- R3: With line_ctl[2] = 0, the stop period is a single 1 bit of 16 ticks.
- R4: With line_ctl[2] = 1, the stop period is two stop bits (32 ticks) for 6, 7 or 8 data bits. For 5 data bits it is one and a half stop bits (24 ticks).
- R5: With line_ctl[3] = 1, a parity bit of 16 ticks follows the last data bit. With line_ctl[3] = 0, no parity bit is sent.
- R6: With line_ctl[4] = 1, the parity is even: the data bits and the parity bit together hold an even number of ones. With line_ctl[4] = 0, that count is odd.
- R7: With line_ctl[5] = 1 and parity enabled, the parity bit is the inverse of line_ctl[4], whatever the data.
- R8: While line_ctl[6] = 1, tx_out is 0, whether the block is idle or transmitting.
- R9: After reset, tx_out is 1, busy is 0 and tx_ready is 1. The captured line control resets to all zeros.
- R10: A character is taken when tx_valid and tx_ready are both 1. The framing fields are sampled in that cycle and held for the whole character. busy stays 1, and tx_ready stays 0, until the stop period has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | tx_data holds a character |
| tx_ready | output | 1 | Block can take a character |
| line_ctl | input | 8 | Framing and break controls |
| tx_out | output | 1 | Serial output line |
| busy | output | 1 | A character is being sent |

## Verification
A wrong bit index or a wrong parity accumulator shows as a wrong line level at the middle of that bit period. This is visible within 8 ticks of the bit starting. A wrong tick counter or a wrong stop length moves the moment busy falls. The bench therefore checks busy one tick before and at the exact tick where the frame should end. Captured-field errors show up when the line control changes right after acceptance: the rest of the frame then takes the new framing.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] line_ctl,
  output logic       tx_out,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] ONE5_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    sh;
  logic [5:0]    lc_q;
  logic          line_q;
  logic          par_acc;

  logic [3:0]    nbits;
  logic [CW-1:0] stop_last;
  logic          bit_end;
  logic          par_next;
  logic          par_bit;

  assign nbits     = {2'b00, lc_q[1:0]} + 4'd5;
  assign stop_last = !lc_q[2] ? BIT_LAST : (lc_q[1:0] == 2'b00 ? ONE5_LAST : TWO_LAST);
  assign bit_end   = baud_tick && cnt == BIT_LAST;
  assign par_next  = par_acc ^ sh[0];
  assign par_bit   = lc_q[5] ? ~lc_q[4] : (lc_q[4] ? par_next : ~par_next);

  assign tx_ready = (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign tx_out   = line_q & ~line_ctl[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      lc_q    <= '0;
      line_q  <= 1'b1;
      par_acc <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (tx_valid) begin
            st      <= S_START;
            sh      <= tx_data;
            lc_q    <= line_ctl[5:0];
            line_q  <= 1'b0;
            cnt     <= '0;
            idx     <= '0;
            par_acc <= 1'b0;
          end
        end
        S_START: begin
          if (bit_end) begin
            st     <= S_DATA;
            cnt    <= '0;
            line_q <= sh[0];
          end else if (baud_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (bit_end) begin
            cnt     <= '0;
            par_acc <= par_next;
            sh      <= sh >> 1;
            idx     <= idx + 1'b1;
            if (idx == nbits - 4'd1) begin
              if (lc_q[3]) begin
                st     <= S_PAR;
                line_q <= par_bit;
              end else begin
                st     <= S_STOP;
                line_q <= 1'b1;
              end
            end else begin
              line_q <= sh[1];
            end
          end else if (baud_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (bit_end) begin
            st     <= S_STOP;
            cnt    <= '0;
            line_q <= 1'b1;
          end else if (baud_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (baud_tick) begin
            if (cnt == stop_last) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] line_ctl,
  input logic       tx_out,
  input logic       busy
);
  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctl[6] |-> !tx_out);

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_ctl[6]) |-> tx_out);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !tx_out));

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && !line_ctl[6]) |=> (line_ctl[6] || $stable(tx_out)));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> busy);

  assert_end_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (.*);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic [7:0] line_ctl = 8'h00;
  logic       tx_ready, tx_out, busy;

  int checks = 0;
  int fails = 0;
  int tick_cnt = 0;
  int base = 0;
  bit done = 0;

  uart_frame_tx dut (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .line_ctl(line_ctl), .tx_out(tx_out), .busy(busy));

  always #5 clk = ~clk;

  always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at tick %0d", tag, act, exp, tick_cnt - base);
    end
  endtask

  task automatic wait_rel(input int t);
    int guard = 0;
    while (tick_cnt - base < t) begin
      @(negedge clk);
      guard++;
      if (guard > 5000) begin
        fails++;
        $display("FAIL R2: wait for tick %0d timed out", t);
        return;
      end
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] lc, input logic [7:0] lc_after);
    int n = 5 + int'(lc[1:0]);
    logic [7:0] m = 8'hFF >> (8 - n);
    logic p = ^(d & m);
    logic pb = lc[5] ? ~lc[4] : (lc[4] ? p : ~p);
    int st_t = lc[2] ? (lc[1:0] == 2'b00 ? 24 : 32) : 16;
    string stag = lc[2] ? "R4" : "R3";
    string ptag = lc[5] ? "R7" : (lc[4] ? "R6 even" : "R6 odd");
    int pos;
    @(negedge clk);
    line_ctl = lc; tx_data = d; tx_valid = 1'b1;
    chk("R10 ready before accept", tx_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; line_ctl = lc_after; base = tick_cnt;
    chk("R10 busy after accept", busy, 1'b1);
    wait_rel(8);
    chk("R2 start bit", tx_out, 1'b0);
    for (int i = 0; i < n; i++) begin
      wait_rel(16 * (i + 1) + 8);
      chk("R1 data bit", tx_out, d[i]);
    end
    pos = 16 * (n + 1);
    if (lc[3]) begin
      wait_rel(pos + 8);
      chk(ptag, tx_out, pb);
      pos += 16;
    end
    wait_rel(pos + 8);
    chk(lc[3] ? stag : "R5 no parity, stop", tx_out, 1'b1);
    if (st_t > 16) begin
      wait_rel(pos + st_t - 4);
      chk(stag, tx_out, 1'b1);
    end
    wait_rel(pos + st_t - 1);
    chk({stag, " busy before end"}, busy, 1'b1);
    chk("R10 not ready in stop", tx_ready, 1'b0);
    wait_rel(pos + st_t);
    chk({stag, " busy cleared"}, busy, 1'b0);
    chk("R2 idle high", tx_out, 1'b1);
  endtask

  task automatic t_reset;
    chk("R9 tx_out", tx_out, 1'b1);
    chk("R9 busy", busy, 1'b0);
    chk("R9 ready", tx_ready, 1'b1);
  endtask

  task automatic t_break;
    @(negedge clk);
    line_ctl = 8'h03; tx_data = 8'hFF; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; base = tick_cnt;
    wait_rel(40);
    chk("R8 line high before break", tx_out, 1'b1);
    line_ctl = 8'h43;
    @(negedge clk);
    chk("R8 break mid frame", tx_out, 1'b0);
    wait_rel(72);
    chk("R8 break held", tx_out, 1'b0);
    chk("R8 frame continues", busy, 1'b1);
    line_ctl = 8'h03;
    @(negedge clk);
    chk("R8 released", tx_out, 1'b1);
    wait_rel(160);
    chk("R3 frame end after break", busy, 1'b0);
    line_ctl = 8'h40;
    @(negedge clk);
    chk("R8 break idle", tx_out, 1'b0);
    line_ctl = 8'h00;
    @(negedge clk);
    chk("R8 idle released", tx_out, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    send(8'hA5, 8'h03, 8'h03);
    send(8'h3C, 8'h03, 8'h03);
    send(8'hFB, 8'h04, 8'h04);
    send(8'h55, 8'h1E, 8'h1E);
    send(8'h2D, 8'h09, 8'h09);
    send(8'h01, 8'h07, 8'h07);
    send(8'hFF, 8'h3B, 8'h3B);
    send(8'h00, 8'h2B, 8'h2B);
    send(8'h0F, 8'h00, 8'h1F);
    send(8'h81, 8'h1B, 8'h08);
    t_break();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule